// File: doc/BRIEF.md
# Stepped Soft-Start Current Limit Sequencer

This block paces the start-up of a constant on-time buck controller. It counts switching periods, not clock edges. An input strobe that pulses once per switching period marks each period. As the count runs, the block raises the allowed valley current limit in four equal steps. The analog current scaling that uses the step code lies outside this block.

While the block is in the first step, it raises two more flags. One tells the off-time one-shot to double its minimum off-time. The other tells the on-time generator to add a small positive offset to its copy of the output voltage. When the fourth step ends, a done flag goes high. This flag arms the under-voltage protection and the power-good logic.

The ramp starts once both the enable input and the supply-undervoltage-ok flag are high. If either input drops at any time, the sequencer clears its count and goes back to idle. The next start then runs the whole ramp again from the first step.

Top module: `ss_ramp_seq`

## Requirements
- R1: During and just after synchronous reset, with the block not started, `lim_code` is 0, and `dbl_off`, `ton_ofs` and `ss_done` are all 0.
- R2: One clock edge after `en` and `uvlo_ok` are both sampled high in idle, the block is in step 1. In step 1, `lim_code` = 0 (25 %), `dbl_off` = 1 and `ton_ofs` = 1.
- R3: Each step lasts exactly CYC_PER_STEP strobes. Clock edges without `cyc_stb` never change the step or the count.
- R4: The step code counts up 0, 1, 2, 3, meaning 25 %, 50 %, 75 % and 100 %. `dbl_off` and `ton_ofs` are high only in step 1. The other steps use the normal off-time and no offset.
- R5: On the clock edge that samples the 4*CYC_PER_STEP-th strobe, `ss_done` goes high with `lim_code` = 3. It stays high for as long as `en` and `uvlo_ok` stay high, and later strobes change nothing.
- R6: When `en` is sampled low, the block returns to idle on that edge and clears its count. A later enable restarts the full ramp at step 1.
- R7: When `uvlo_ok` is sampled low, the effect is the same as for `en`. The idle state and the cleared count mean that the next ramp begins from zero.
- R8: `cyc_stb` pulses given while idle have no effect on the outputs or on the later ramp length.
- R9: `ss_done` is never high together with `dbl_off` or `ton_ofs`. While the block stays enabled, `lim_code` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| uvlo_ok | input | 1 | Supply above undervoltage lockout |
| cyc_stb | input | 1 | One-clock pulse per switching period |
| lim_code | output | 2 | Current-limit scale: 0=25 %, 1=50 %, 2=75 %, 3=100 % |
| dbl_off | output | 1 | Double the minimum off-time |
| ton_ofs | output | 1 | Add start-up offset to the on-time voltage input |
| ss_done | output | 1 | Ramp complete; arms under-voltage and power-good logic |

## Verification
The bench drives several input patterns:

- **Strobe every clock.** A full ramp with a strobe on every clock edge shows that the step boundaries fall on exact strobe counts.
- **Sparse strobes.** A second ramp with strobes on only every third clock separates counting strobes from counting clock edges.
- **Aborts.** Runs are cut short by dropping `en` or `uvlo_ok` in the middle of a step. Strobes sent while idle then show whether the count really clears and whether idle strobes leak into the next ramp.
- **Strobes after done.** Strobes continue after completion, to show that the done state holds.

// File: rtl/ss_ramp_pkg.sv
package ss_ramp_pkg;

    typedef enum logic [2:0] {
        SS_IDLE = 3'd0,
        SS_P1   = 3'd1,
        SS_P2   = 3'd2,
        SS_P3   = 3'd3,
        SS_P4   = 3'd4,
        SS_DONE = 3'd5
    } ss_phase_e;

    typedef struct packed {
        logic [1:0] lim_code;
        logic       dbl_off;
        logic       ton_ofs;
        logic       done;
    } ss_out_t;

    function automatic logic phase_running(input ss_phase_e ph);
        return (ph == SS_P1) || (ph == SS_P2) || (ph == SS_P3) || (ph == SS_P4);
    endfunction

    function automatic ss_phase_e phase_after(input ss_phase_e ph);
        case (ph)
            SS_P1:   return SS_P2;
            SS_P2:   return SS_P3;
            SS_P3:   return SS_P4;
            SS_P4:   return SS_DONE;
            default: return ph;
        endcase
    endfunction

endpackage

// File: rtl/ss_step_cnt.sv
module ss_step_cnt #(
    parameter int CYC_PER_STEP = 110
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic wrap
);
    localparam int CNT_W = (CYC_PER_STEP > 1) ? $clog2(CYC_PER_STEP) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_PER_STEP - 1);

    logic [CNT_W-1:0] cnt_q;

    assign wrap = inc && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(cnt_q));

    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/ss_phase_fsm.sv
module ss_phase_fsm
    import ss_ramp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      act,
    input  logic      wrap,
    output ss_phase_e phase
);
    ss_phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            ph_q <= SS_IDLE;
        end else begin
            case (ph_q)
                SS_IDLE: ph_q <= SS_P1;
                SS_DONE: ph_q <= SS_DONE;
                default: if (wrap) ph_q <= phase_after(ph_q);
            endcase
        end
    end

    assign phase = ph_q;

    p_idle_on_drop_r6: assert property (@(posedge clk) disable iff (rst)
        !act |=> (ph_q == SS_IDLE));

    p_start_p1_r2: assert property (@(posedge clk) disable iff (rst)
        (act && ph_q == SS_IDLE) |=> (ph_q == SS_P1));

    p_hold_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (act && !wrap && ph_q != SS_IDLE) |=> $stable(ph_q));

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (act && ph_q == SS_DONE) |=> (ph_q == SS_DONE));

endmodule

// File: rtl/ss_out_dec.sv
module ss_out_dec
    import ss_ramp_pkg::*;
(
    input  ss_phase_e phase,
    output ss_out_t   outs
);
    always_comb begin
        outs = '0;
        case (phase)
            SS_P1: begin
                outs.lim_code = 2'd0;
                outs.dbl_off  = 1'b1;
                outs.ton_ofs  = 1'b1;
            end
            SS_P2:   outs.lim_code = 2'd1;
            SS_P3:   outs.lim_code = 2'd2;
            SS_P4:   outs.lim_code = 2'd3;
            SS_DONE: begin
                outs.lim_code = 2'd3;
                outs.done     = 1'b1;
            end
            default: outs = '0;
        endcase
    end

    always_comb begin
        a_done_excl_r9: assert (!(outs.done && (outs.dbl_off || outs.ton_ofs)));
    end

endmodule

// File: rtl/ss_ramp_seq.sv
module ss_ramp_seq
    import ss_ramp_pkg::*;
#(
    parameter int CYC_PER_STEP = 110
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       uvlo_ok,
    input  logic       cyc_stb,
    output logic [1:0] lim_code,
    output logic       dbl_off,
    output logic       ton_ofs,
    output logic       ss_done
);
    logic      act;
    logic      running;
    logic      wrap;
    ss_phase_e phase;
    ss_out_t   outs;

    assign act     = en && uvlo_ok;
    assign running = phase_running(phase);

    ss_step_cnt #(.CYC_PER_STEP(CYC_PER_STEP)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (!act),
        .inc  (cyc_stb && running && act),
        .wrap (wrap)
    );

    ss_phase_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .wrap  (wrap),
        .phase (phase)
    );

    ss_out_dec u_dec (
        .phase (phase),
        .outs  (outs)
    );

    assign lim_code = outs.lim_code;
    assign dbl_off  = outs.dbl_off;
    assign ton_ofs  = outs.ton_ofs;
    assign ss_done  = outs.done;

    p_code_mono_r9: assert property (@(posedge clk) disable iff (rst)
        (act && phase != SS_IDLE) |=> (lim_code >= $past(lim_code)));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !act |=> (!ss_done && !dbl_off && !ton_ofs && lim_code == 2'd0));

    p_first_flags_r4: assert property (@(posedge clk) disable iff (rst)
        dbl_off |-> (ton_ofs && lim_code == 2'd0));

endmodule

// File: tb/sim_ss_ramp_seq.sv
module sim_ss_ramp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int STEP = 110;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, uvlo_ok = 1'b0, cyc_stb = 1'b0;
    logic [1:0] lim_code;
    logic dbl_off, ton_ofs, ss_done;

    int checks = 0;
    int fails = 0;
    string tag = "R1";
    int m_ph = 0;
    int m_cnt = 0;
    int prev_code = 0;
    bit last_act = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ss_ramp_seq #(.CYC_PER_STEP(STEP)) u0 (
        .clk(clk), .rst(rst), .en(en), .uvlo_ok(uvlo_ok), .cyc_stb(cyc_stb),
        .lim_code(lim_code), .dbl_off(dbl_off), .ton_ofs(ton_ofs), .ss_done(ss_done)
    );

    // behavioural reference: phase 0 idle, 1..4 steps, 5 done
    always @(posedge clk) begin
        if (rst || !(en && uvlo_ok)) begin
            m_ph  <= 0;
            m_cnt <= 0;
        end else if (m_ph == 0) begin
            m_ph <= 1;
        end else if (m_ph <= 4 && cyc_stb) begin
            if (m_cnt == STEP - 1) begin
                m_cnt <= 0;
                m_ph  <= m_ph + 1;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string t, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", t, act_v, exp_v, $time);
        end
    endtask

    task automatic compare();
        int e_code;
        bit e_first;
        bit e_done;
        e_code  = (m_ph >= 1 && m_ph <= 4) ? m_ph - 1 : (m_ph == 5 ? 3 : 0);
        e_first = (m_ph == 1);
        e_done  = (m_ph == 5);
        chk(lim_code == e_code[1:0], {tag, " lim_code"}, lim_code, e_code);
        chk(dbl_off == e_first, {tag, " dbl_off"}, dbl_off, e_first);
        chk(ton_ofs == e_first, {tag, " ton_ofs"}, ton_ofs, e_first);
        chk(ss_done == e_done, {tag, " ss_done"}, ss_done, e_done);
        chk(!(ss_done && (dbl_off || ton_ofs)), "R9 done with start flags", ss_done, 0);
        if (last_act)
            chk(int'(lim_code) >= prev_code, "R9 code decreased", lim_code, prev_code);
        prev_code = lim_code;
    endtask

    task automatic step(input bit e, input bit o, input bit s);
        @(negedge clk);
        compare();
        en = e; uvlo_ok = o; cyc_stb = s;
        last_act = e && o && !rst;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) step(0, 0, 0);
        @(negedge clk); rst = 1'b0;
        repeat (2) step(0, 0, 0);
        chk(lim_code == 0 && !dbl_off && !ton_ofs && !ss_done, "R1 reset outputs", lim_code, 0);

        // R8: strobes while idle
        tag = "R8";
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1);

        // R2: start into step 1
        tag = "R2";
        step(1, 1, 0);
        step(1, 1, 0);
        chk(dbl_off == 1 && ton_ofs == 1 && lim_code == 0, "R2 step1 flags", dbl_off, 1);

        // R3/R4/R5: dense strobes, full ramp
        tag = "R4";
        for (int i = 0; i < 4 * STEP; i++) begin
            tag = (i % STEP == STEP - 1) ? "R3" : "R4";
            step(1, 1, 1);
        end
        step(1, 1, 0);
        step(1, 1, 0);
        chk(ss_done == 1 && lim_code == 3, "R5 done after 440 strobes", ss_done, 1);

        // R5: strobes after done
        tag = "R5";
        for (int i = 0; i < 30; i++) step(1, 1, i[0]);
        chk(ss_done == 1, "R5 done held", ss_done, 1);

        // R6: drop enable
        tag = "R6";
        step(0, 1, 1);
        step(0, 1, 1);
        chk(ss_done == 0 && lim_code == 0, "R6 idle after enable drop", ss_done, 0);

        // R3: sparse strobes, restart, abort mid step 3 via uvlo
        tag = "R3";
        step(1, 1, 0);
        for (int i = 0; i < 2 * STEP + 40; i++) begin
            step(1, 1, 0);
            step(1, 1, 0);
            step(1, 1, 1);
        end
        step(1, 1, 0);
        chk(lim_code == 2, "R3 step3 after sparse strobes", lim_code, 2);
        tag = "R7";
        step(1, 0, 1);
        step(1, 0, 0);
        chk(lim_code == 0 && !dbl_off, "R7 idle after uvlo drop", lim_code, 0);

        // R7/R6: restart must take the full ramp again
        tag = "R7";
        step(1, 1, 0);
        for (int i = 0; i < STEP - 1; i++) step(1, 1, 1);
        step(1, 1, 0);
        chk(dbl_off == 1 && lim_code == 0, "R7 still step1 after STEP-1 strobes", dbl_off, 1);
        step(1, 1, 1);
        step(1, 1, 0);
        chk(dbl_off == 0 && lim_code == 1, "R7 step2 after STEP strobes", lim_code, 1);

        // R6: abort mid step 2 by enable, then restart
        tag = "R6";
        for (int i = 0; i < 50; i++) step(1, 1, 1);
        step(0, 0, 1);
        step(1, 1, 0);
        for (int i = 0; i < STEP + 5; i++) step(1, 1, i % 2 == 0);
        step(1, 1, 0);
        step(1, 1, 0);
        finish_run();
    end
endmodule